// File: doc/BRIEF.md
# UART Interrupt Identification Register

This block holds the interrupt identification logic of a 16550-class UART whose FIFOs run at a depth of 16 or 64 bytes. It takes five interrupt requests, each with its own enable bit. The requests are receive line error, receive timeout, receive data ready, transmit holding empty and modem status change. The block encodes the most urgent enabled request into an 8-bit status value that the host can read. It also drives a single interrupt line to the host.

Four of the requests are plain levels owned by other logic, and they drop when that logic drops them. The transmit-holding-empty request is the only one latched here. It is set by an empty event. It is cleared by a holding-register write, or by a host read that reports it. A read returns the value captured on the clock edge of its strobe. A read acknowledges only the request it reported, so any lower-level request still pending shows on the following read. The upper bits of the value report whether the FIFOs are on and whether the deep mode is selected.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset the read data is 0x01, `irq_o` is low and the latched transmit-empty flag is clear.
- R2: When exactly one source is pending and enabled, bits 3..0 of the read value are: line error 0110, receive timeout 1100, data ready 0100, transmit holding empty 0010, modem status 0000.
- R3: With several enabled sources pending, only the highest is encoded. The order from highest is line error, receive timeout, data ready, transmit holding empty, modem status.
- R4: `ien_i` gates each source: bit 0 line error, bit 1 receive timeout, bit 2 data ready, bit 3 transmit holding empty, bit 4 modem status. A source whose bit is 0 is neither encoded nor able to raise `irq_o`.
- R5: `irq_o` is high in the same cycle as any enabled source is pending, and low otherwise.
- R6: Bit 0 of the read value is 0 when an enabled source is pending and 1 when none is.
- R7: `rd_data_o` takes the status as it stands in the cycle in which `rd_i` is high. It becomes visible after that clock edge and holds until the next read.
- R8: A read that reports transmit holding empty (code 0010) clears the latched flag, so a pending modem status shows on the next read.
- R9: A read that reports a higher source leaves the transmit-empty flag set, and the flag is reported by a later read.
- R10: A pulse on `thr_write_i` clears the transmit-empty flag.
- R11: An empty event (`thr_empty_i`) in the same cycle as a clearing read or write leaves the flag set.
- R12: Bits 7..6 read 11 when `fifo_en_i` is 1 and 00 otherwise. Bit 5 reads `fifo_en_i & fifo64_i`. Bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lsr_req_i | input | 1 | Receive line error request, level |
| rxto_req_i | input | 1 | Receive timeout request, level |
| rxrdy_req_i | input | 1 | Receive data ready request, level |
| msr_req_i | input | 1 | Modem status change request, level |
| thr_empty_i | input | 1 | Transmit holding empty event, one cycle |
| thr_write_i | input | 1 | Holding-register write strobe |
| ien_i | input | 5 | Per-source enables |
| fifo_en_i | input | 1 | FIFOs enabled |
| fifo64_i | input | 1 | 64-byte mode selected |
| rd_i | input | 1 | Host read strobe of the status register |
| rd_data_o | output | 8 | Status value captured by the last read |
| irq_o | output | 1 | Interrupt output to the host |

## Verification
Each source is first driven alone, which shows its code separately from its priority. Pairs of sources are then driven, which shows the priority order, including timeout over data ready. The latched flag is tested with reads that report it, reads that report a higher source, writes, and events that coincide with a clear. These cases show that a read acknowledges only what it reports. Long random runs mix all inputs against a reference model. This catches mistakes in masking, in how `irq_o` is tied to the enables, and in the upper mode bits.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC    = 5;
    localparam int IDW     = 4;
    localparam int STATW   = 8;
    localparam int SELW    = $clog2(NSRC);

    // Index equals priority rank: 0 is the most urgent.
    typedef enum logic [SELW-1:0] {
        SRC_LSR   = 3'd0,
        SRC_RXTO  = 3'd1,
        SRC_RXRDY = 3'd2,
        SRC_THRE  = 3'd3,
        SRC_MSR   = 3'd4
    } src_e;

    localparam logic [IDW-1:0] ID_LSR   = 4'b0110;
    localparam logic [IDW-1:0] ID_RXTO  = 4'b1100;
    localparam logic [IDW-1:0] ID_RXRDY = 4'b0100;
    localparam logic [IDW-1:0] ID_THRE  = 4'b0010;
    localparam logic [IDW-1:0] ID_MSR   = 4'b0000;
    localparam logic [IDW-1:0] ID_NONE  = 4'b0001;

    typedef struct packed {
        logic [1:0]     fifo_on;
        logic           deep;
        logic           spare;
        logic [IDW-1:0] id;
    } status_t;

    localparam status_t STATUS_RST = '{fifo_on: 2'b00, deep: 1'b0,
                                       spare: 1'b0, id: ID_NONE};

    function automatic logic [IDW-1:0] id_of(input src_e s);
        case (s)
            SRC_LSR:   return ID_LSR;
            SRC_RXTO:  return ID_RXTO;
            SRC_RXRDY: return ID_RXRDY;
            SRC_THRE:  return ID_THRE;
            default:   return ID_MSR;
        endcase
    endfunction

    function automatic status_t build_status(input logic any,
                                             input logic [IDW-1:0] id,
                                             input logic fifo_en,
                                             input logic fifo64);
        status_t s;
        s.fifo_on = {2{fifo_en}};
        s.deep    = fifo_en & fifo64;
        s.spare   = 1'b0;
        s.id      = any ? id : ID_NONE;
        return s;
    endfunction

endpackage

// File: rtl/uart_irq_thre_flag.sv
module uart_irq_thre_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic wr_clr_i,
    input  logic rd_ack_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;       // a new event outranks any clear
        else if (wr_clr_i || rd_ack_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    output logic            any_o,
    output src_e            sel_o,
    output logic [IDW-1:0]  id_o
);
    logic [NSRC-1:0] live;

    for (genvar g = 0; g < NSRC; g++) begin : g_mask
        assign live[g] = req_i[g] & en_i[g];
    end

    always_comb begin
        sel_o = SRC_MSR;
        for (int i = NSRC-1; i >= 0; i--) begin
            if (live[i]) sel_o = src_e'(i);
        end
    end

    assign any_o = |live;
    assign id_o  = id_of(sel_o);
endmodule

// File: rtl/uart_irq_rdport.sv
module uart_irq_rdport
    import uart_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_i,
    input  status_t live_i,
    output status_t data_o
);
    always_ff @(posedge clk) begin
        if (rst)
            data_o <= STATUS_RST;
        else if (rd_i)
            data_o <= live_i;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lsr_req_i,
    input  logic              rxto_req_i,
    input  logic              rxrdy_req_i,
    input  logic              msr_req_i,
    input  logic              thr_empty_i,
    input  logic              thr_write_i,
    input  logic [NSRC-1:0]   ien_i,
    input  logic              fifo_en_i,
    input  logic              fifo64_i,
    input  logic              rd_i,
    output logic [STATW-1:0]  rd_data_o,
    output logic              irq_o
);
    logic            thre_pend;
    logic [NSRC-1:0] req_vec;
    logic            any_live;
    src_e            sel;
    logic [IDW-1:0]  sel_id;
    logic            rd_ack;
    status_t         live_stat;
    status_t         held_stat;

    always_comb begin
        req_vec            = '0;
        req_vec[SRC_LSR]   = lsr_req_i;
        req_vec[SRC_RXTO]  = rxto_req_i;
        req_vec[SRC_RXRDY] = rxrdy_req_i;
        req_vec[SRC_THRE]  = thre_pend;
        req_vec[SRC_MSR]   = msr_req_i;
    end

    uart_irq_prio prio_i (
        .req_i (req_vec),
        .en_i  (ien_i),
        .any_o (any_live),
        .sel_o (sel),
        .id_o  (sel_id)
    );

    assign rd_ack = rd_i && any_live && (sel == SRC_THRE);

    uart_irq_thre_flag thre_i (
        .clk      (clk),
        .rst      (rst),
        .set_i    (thr_empty_i),
        .wr_clr_i (thr_write_i),
        .rd_ack_i (rd_ack),
        .flag_o   (thre_pend)
    );

    assign live_stat = build_status(any_live, sel_id, fifo_en_i, fifo64_i);

    uart_irq_rdport rdport_i (
        .clk    (clk),
        .rst    (rst),
        .rd_i   (rd_i),
        .live_i (live_stat),
        .data_o (held_stat)
    );

    assign rd_data_o = held_stat;
    assign irq_o     = any_live;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_i,
    input logic       thr_empty_i,
    input logic       thr_write_i,
    input logic       fifo_en_i,
    input logic       fifo64_i,
    input logic       irq_o,
    input logic [7:0] rd_data_o,
    input logic       thre_q
);
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (rd_data_o == 8'h01 && !thre_q));

    a_r6_bit0_vs_irq: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> (rd_data_o[0] == !$past(irq_o)));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rd_data_o));

    a_r8_read_ack: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !thr_empty_i) |=> (rd_data_o[3:0] != 4'b0010 || !thre_q));

    a_r10_write_clear: assert property (@(posedge clk) disable iff (rst)
        (thr_write_i && !thr_empty_i) |=> !thre_q);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        thr_empty_i |=> thre_q);

    a_r12_mode_bits: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> (rd_data_o[7:6] == {2{$past(fifo_en_i)}} &&
                  rd_data_o[5] == ($past(fifo_en_i) && $past(fifo64_i)) &&
                  !rd_data_o[4]));
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .rd_i        (rd_i),
    .thr_empty_i (thr_empty_i),
    .thr_write_i (thr_write_i),
    .fifo_en_i   (fifo_en_i),
    .fifo64_i    (fifo64_i),
    .irq_o       (irq_o),
    .rd_data_o   (rd_data_o),
    .thre_q      (thre_pend)
);

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/100ps
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lsr = 0, rxto = 0, rxrdy = 0, msr = 0;
    logic       tev = 0, twr = 0, rd = 0;
    logic [4:0] ien = '0;
    logic       fen = 0, f64 = 0;
    logic [7:0] rd_data;
    logic       irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic       m_flag = 0;
    logic [7:0] m_rd = 8'h01;

    always #2.5 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst(rst), .lsr_req_i(lsr), .rxto_req_i(rxto),
        .rxrdy_req_i(rxrdy), .msr_req_i(msr), .thr_empty_i(tev),
        .thr_write_i(twr), .ien_i(ien), .fifo_en_i(fen), .fifo64_i(f64),
        .rd_i(rd), .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic logic [7:0] exp_stat(logic flag);
        logic [3:0] id;
        if      (lsr   && ien[0]) id = 4'b0110;
        else if (rxto  && ien[1]) id = 4'b1100;
        else if (rxrdy && ien[2]) id = 4'b0100;
        else if (flag  && ien[3]) id = 4'b0010;
        else if (msr   && ien[4]) id = 4'b0000;
        else                      id = 4'b0001;
        return {fen, fen, fen & f64, 1'b0, id};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // One cycle: inputs already driven after a negedge.
    task automatic step(string req);
        logic [7:0] e;
        #1;
        e = exp_stat(m_flag);
        check("R5 irq", {7'b0, irq}, {7'b0, !e[0]});
        @(posedge clk);
        if (rd) m_rd = e;
        if (tev) m_flag = 1;
        else if (twr || (rd && e[3:0] == 4'b0010)) m_flag = 0;
        @(negedge clk);
        check(req, rd_data, m_rd);
        tev = 0; twr = 0; rd = 0;
    endtask

    task automatic do_read(string req);
        rd = 1; step(req);
    endtask

    task automatic clear_all();
        lsr = 0; rxto = 0; rxrdy = 0; msr = 0; twr = 1; step("R10 clr");
    endtask

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1234));
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 reset data", rd_data, 8'h01);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        ien = 5'h1f;
        do_read("R1 flag clear after reset");

        // R2 each source alone
        lsr = 1;   do_read("R2 lsr 0110");   lsr = 0;
        rxto = 1;  do_read("R2 rxto 1100");  rxto = 0;
        rxrdy = 1; do_read("R2 rxrdy 0100"); rxrdy = 0;
        msr = 1;   do_read("R2 msr 0000");   msr = 0;
        tev = 1;   step("R2 set thre");
        do_read("R2 thre 0010");
        do_read("R8 thre gone after read");

        // R3 priority pairs
        lsr = 1; rxto = 1; do_read("R3 lsr over rxto"); lsr = 0;
        rxrdy = 1; do_read("R3 rxto over rxrdy"); rxto = 0;
        msr = 1; do_read("R3 rxrdy over msr"); clear_all();

        // R4 masking
        lsr = 1; msr = 1; ien = 5'b10000; do_read("R4 lsr masked");
        ien = 5'b00000; do_read("R4 all masked");
        check("R4 irq low when masked", {7'b0, irq}, 8'h00);
        ien = 5'h1f; clear_all();

        // R8 and R9: thre vs lower/higher sources
        tev = 1; msr = 1; step("R8 set");
        do_read("R8 reports thre");
        do_read("R8 msr next");
        tev = 1; lsr = 1; step("R9 set");
        do_read("R9 lsr reported");
        lsr = 0; do_read("R9 thre still pending");
        // R10 write clear
        tev = 1; step("R10 set");
        twr = 1; step("R10 write");
        do_read("R10 msr after write"); msr = 0;
        // R11 set wins over read clear and write clear
        tev = 1; step("R11 set");
        tev = 1; rd = 1; step("R11 event during read");
        do_read("R11 thre survives read");
        tev = 1; twr = 1; step("R11 event with write");
        do_read("R11 thre survives write");

        // R12 mode bits
        fen = 1; f64 = 1; do_read("R12 fifo64");
        f64 = 0; do_read("R12 fifo16");
        fen = 0; f64 = 1; do_read("R12 fifo off");
        // R7 hold without read
        fen = 1; lsr = 1; step("R7 hold no read"); lsr = 0;

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            lsr   = ($urandom % 5) == 0;
            rxto  = ($urandom % 4) == 0;
            rxrdy = ($urandom % 3) == 0;
            msr   = ($urandom % 3) == 0;
            tev   = ($urandom % 4) == 0;
            twr   = ($urandom % 6) == 0;
            rd    = ($urandom % 2) == 0;
            ien   = 5'($urandom);
            fen   = ($urandom % 4) != 0;
            f64   = $urandom % 2;
            step("R3 random read");
        end
        finish_run();
    end
endmodule